// File: doc/BRIEF.md
# Sliding-Window DC Removal Filter

This block strips the slowly varying mean from a stream of signed fixed-point samples. It keeps the samples of exactly one mains period and a running total of them. Each accepted sample is added to the total, and the sample taken one period earlier is removed from it. The total is scaled by a fixed reciprocal of the window length to give the mean over the period. The mean is then subtracted from the newest sample. What remains is the alternating part of the signal. The mean itself is also brought out. A typical use is high-pass filtering a direct-axis current so that only its non-fundamental content is left for compensation.

Samples are signed 14-bit words with 13 fractional bits, so the LSB is 2^-13. They arrive with a valid strobe at a rate far below the clock. A select input picks a window of one 50 Hz period (1000 samples) or one 60 Hz period (833 samples). A controller with two states drives the window:

- FILL: the window is still being loaded. Nothing is taken out of the total, and no result is flagged valid.
- RUN: the window is complete. Every accepted sample produces a valid result.

The controller has three transitions:

- WINDOW_DONE (FILL to RUN): the last slot of the window is written.
- RESTART (any state to FILL): the select changes value.
- HOLD: no change in any other case.

Top module: `sliding_dc_remover`

## Requirements
- R1: After rst_n is released and before any sample is accepted, out_valid is 0 and ac_out and dc_out are both 0.
- R2: With freq_sel=0 the window holds N=1000 samples. With freq_sel=1 it holds N=833 samples. The first valid result belongs to the Nth accepted sample.
- R3: For each valid result, dc_out = clamp(floor(S*K / 2^24)). S is the integer sum of the last N accepted samples, and K = round(2^24/N), which gives 16777 for N=1000 and 20141 for N=833.
- R4: For each valid result, ac_out = clamp(x - dc_out), where x is the sample that produced it.
- R5: ac_out saturates to 8191 when the difference is above that value and to -8192 when it is below that value.
- R6: dc_out saturates in the same way. For example, a full 833-sample window of -8192 gives dc_out = -8192.
- R7: out_valid stays 0 for the first N-1 samples accepted after reset or a restart. After that, it pulses high for exactly one cycle for every accepted sample.
- R8: A sample is accepted at clock edge k. Its out_valid pulse and its updated ac_out and dc_out appear after edge k+1. Between results, ac_out and dc_out hold their values.
- R9: freq_sel is compared with its value at the previous edge. When it differs, the filter restarts: the total and the history are cleared, and a sample strobed in that same cycle is discarded.
- R10: A cycle with in_valid low produces no pulse, changes no output and does not advance the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_sel | input | 1 | Window select: 0 selects the 1000-sample window, 1 selects the 833-sample window |
| in_valid | input | 1 | Strobe marking a new sample on in_data |
| in_data | input | 14 | Signed sample with 13 fractional bits |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| ac_out | output | 14 | Input minus the window mean, saturated |
| dc_out | output | 14 | Window mean, saturated |

## Verification
A sample presented at one falling edge is taken on the next rising edge. Its result registers land one rising edge after that. The bench therefore checks out_valid, ac_out and dc_out at the second falling edge after it raises in_valid. Idle cycles are checked at every falling edge after a result, to confirm the pulse lasts one cycle and the values hold. A sample strobed in the cycle of a select change is left out of the bench's own window model. The exact point at which the first valid pulse appears then shows whether the design discarded it.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } win_state_t;
endpackage

// File: rtl/sdr_window_ctrl.sv
module sdr_window_ctrl
    import sdr_pkg::*;
#(
    parameter int WIN_A = 1000,
    parameter int WIN_B = 833,
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             freq_sel,
    output logic             take,
    output logic             restart,
    output logic             sub_en,
    output logic             win_full,
    output logic             sel_q,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST_A = PTR_W'(WIN_A - 1);
    localparam logic [PTR_W-1:0] LAST_B = PTR_W'(WIN_B - 1);

    win_state_t       state, state_nxt;
    logic [PTR_W-1:0] win_last;
    logic             last_slot;

    assign win_last  = sel_q ? LAST_B : LAST_A;
    assign last_slot = (ptr == win_last);
    assign restart   = (freq_sel != sel_q);
    assign take      = in_valid & ~restart;

    // transition logic: WINDOW_DONE, RESTART, HOLD
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL: begin
                if (restart)
                    state_nxt = ST_FILL;
                else if (take && last_slot)
                    state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (restart)
                    state_nxt = ST_FILL;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_FILL;
        else
            state <= state_nxt;
    end

    // write pointer and latched window select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= '0;
            sel_q <= 1'b0;
        end else if (restart) begin
            ptr   <= '0;
            sel_q <= freq_sel;
        end else if (take) begin
            ptr <= last_slot ? '0 : ptr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sub_en   = 1'b0;
        win_full = last_slot;
        unique case (state)
            ST_FILL: begin
                sub_en   = 1'b0;
                win_full = last_slot;
            end
            ST_RUN: begin
                sub_en   = 1'b1;
                win_full = 1'b1;
            end
        endcase
    end

    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= win_last);

    assert_fill_to_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && take && last_slot) |=> (state == ST_RUN));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == ST_FILL && ptr == '0));
endmodule

// File: rtl/sdr_delay_line.sv
module sdr_delay_line #(
    parameter int DATA_W = 14,
    parameter int DEPTH  = 1000,
    parameter int PTR_W  = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // read returns the value stored one window ago, before this edge's write
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end
endmodule

// File: rtl/sdr_accumulator.sv
module sdr_accumulator #(
    parameter int DATA_W  = 14,
    parameter int ACC_W   = 24,
    parameter int MAX_WIN = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic                     take,
    input  logic                     sub_en,
    input  logic                     win_full,
    input  logic                     sel_in,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] old,
    output logic signed [ACC_W-1:0]  acc_q,
    output logic signed [DATA_W-1:0] x_q,
    output logic                     sel_q,
    output logic                     v_q
);
    localparam int    EXT_W     = ACC_W - DATA_W;
    localparam longint ACC_BOUND = longint'(MAX_WIN) <<< (DATA_W - 1);

    logic signed [ACC_W-1:0] x_ext, old_ext;

    assign x_ext   = {{EXT_W{x[DATA_W-1]}}, x};
    assign old_ext = sub_en ? {{EXT_W{old[DATA_W-1]}}, old} : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            x_q   <= '0;
            sel_q <= 1'b0;
            v_q   <= 1'b0;
        end else begin
            v_q <= take & win_full;
            if (restart) begin
                acc_q <= '0;
            end else if (take) begin
                acc_q <= acc_q + x_ext - old_ext;
                x_q   <= x;
                sel_q <= sel_in;
            end
        end
    end

    assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(acc_q) <= ACC_BOUND) && (longint'(acc_q) >= -ACC_BOUND));
endmodule

// File: rtl/sdr_output_stage.sv
module sdr_output_stage #(
    parameter int DATA_W   = 14,
    parameter int ACC_W    = 24,
    parameter int RECIP_W  = 16,
    parameter int RECIP_SH = 24,
    parameter int RECIP_A  = 16777,
    parameter int RECIP_B  = 20141
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic                     sel_in,
    input  logic signed [ACC_W-1:0]  acc,
    input  logic signed [DATA_W-1:0] x,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] ac_out,
    output logic signed [DATA_W-1:0] dc_out
);
    localparam int PROD_W = ACC_W + RECIP_W + 1;
    localparam int DIFF_W = DATA_W + 1;
    localparam logic signed [PROD_W-1:0] P_MAX = PROD_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] P_MIN = ~P_MAX;
    localparam logic signed [DIFF_W-1:0] D_MAX = DIFF_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [DIFF_W-1:0] D_MIN = ~D_MAX;

    logic        [RECIP_W-1:0]  recip;
    logic signed [PROD_W-1:0]   prod, avg_wide;
    logic signed [DATA_W-1:0]   avg_sat, diff_sat;
    logic signed [DIFF_W-1:0]   diff;

    assign recip    = sel_in ? RECIP_W'(RECIP_B) : RECIP_W'(RECIP_A);
    assign prod     = acc * $signed({1'b0, recip});
    assign avg_wide = prod >>> RECIP_SH;

    always_comb begin
        if (avg_wide > P_MAX)
            avg_sat = P_MAX[DATA_W-1:0];
        else if (avg_wide < P_MIN)
            avg_sat = P_MIN[DATA_W-1:0];
        else
            avg_sat = avg_wide[DATA_W-1:0];
    end

    assign diff = {x[DATA_W-1], x} - {avg_sat[DATA_W-1], avg_sat};

    always_comb begin
        if (diff > D_MAX)
            diff_sat = D_MAX[DATA_W-1:0];
        else if (diff < D_MIN)
            diff_sat = D_MIN[DATA_W-1:0];
        else
            diff_sat = diff[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ac_out    <= '0;
            dc_out    <= '0;
        end else begin
            out_valid <= v_in;
            if (v_in) begin
                ac_out <= diff_sat;
                dc_out <= avg_sat;
            end
        end
    end

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> ($stable(ac_out) && $stable(dc_out)));
endmodule

// File: rtl/sliding_dc_remover.sv
module sliding_dc_remover #(
    parameter int DATA_W   = 14,
    parameter int WIN_A    = 1000,
    parameter int WIN_B    = 833,
    parameter int ACC_W    = 24,
    parameter int RECIP_W  = 16,
    parameter int RECIP_SH = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     freq_sel,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] ac_out,
    output logic signed [DATA_W-1:0] dc_out
);
    localparam int DEPTH   = (WIN_A > WIN_B) ? WIN_A : WIN_B;
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int RECIP_A = ((1 << RECIP_SH) + WIN_A / 2) / WIN_A;
    localparam int RECIP_B = ((1 << RECIP_SH) + WIN_B / 2) / WIN_B;

    logic                     take, restart, sub_en, win_full, sel_q;
    logic [PTR_W-1:0]         ptr;
    logic [DATA_W-1:0]        old_raw;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [DATA_W-1:0] x_q;
    logic                     sel_d, v_q;

    sdr_window_ctrl #(.WIN_A(WIN_A), .WIN_B(WIN_B), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .freq_sel(freq_sel),
        .take(take), .restart(restart), .sub_en(sub_en), .win_full(win_full),
        .sel_q(sel_q), .ptr(ptr)
    );

    sdr_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_line (
        .clk(clk), .we(take), .addr(ptr), .wdata(in_data), .rdata(old_raw)
    );

    sdr_accumulator #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MAX_WIN(DEPTH)) u_acc (
        .clk(clk), .rst_n(rst_n), .restart(restart), .take(take),
        .sub_en(sub_en), .win_full(win_full), .sel_in(sel_q),
        .x(in_data), .old($signed(old_raw)),
        .acc_q(acc_q), .x_q(x_q), .sel_q(sel_d), .v_q(v_q)
    );

    sdr_output_stage #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .RECIP_W(RECIP_W), .RECIP_SH(RECIP_SH),
        .RECIP_A(RECIP_A), .RECIP_B(RECIP_B)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .v_in(v_q), .sel_in(sel_d),
        .acc(acc_q), .x(x_q),
        .out_valid(out_valid), .ac_out(ac_out), .dc_out(dc_out)
    );

    assert_valid_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(take, 2));

    assert_no_result_on_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !v_q);
endmodule

// File: tb/tb_sliding_dc_remover.sv
module tb_sliding_dc_remover;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               freq_sel = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [13:0] in_data = '0;
    logic               out_valid;
    logic signed [13:0] ac_out, dc_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sliding_dc_remover dut (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .ac_out(ac_out), .dc_out(dc_out)
    );

    // segments: select, kind (0 const, 1 alternating, 2 ramp), amplitude, offset, length
    localparam int TBL [5][5] = '{
        '{0, 0,    0,  3000, 1000},
        '{0, 1, 2000,   500, 1300},
        '{1, 2,    0,     0, 1000},
        '{1, 0,    0, -8192,  900},
        '{0, 1, 8191,     0, 1100}
    };

    // reference model of the window
    int     hist [1000];
    int     hidx, mcnt, mwin, cur_sel;
    longint msum;
    int     exp_ac, exp_dc;
    bit     exp_v, ac_clip, dc_clip;

    function automatic int clip14(longint v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return int'(v);
    endfunction

    task automatic chk(string tag, longint act, longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_restart(int sel);
        cur_sel = sel;
        mwin = sel ? 833 : 1000;
        hidx = 0; mcnt = 0; msum = 0;
    endtask

    task automatic model_take(int x);
        int     old;
        longint k, p, avgw;
        old = (mcnt >= mwin) ? hist[hidx] : 0;
        msum = msum + x - old;
        hist[hidx] = x;
        hidx = (hidx + 1) % mwin;
        mcnt++;
        exp_v = (mcnt >= mwin);
        k = ((64'sd1 <<< 24) + mwin / 2) / mwin;
        p = msum * k;
        avgw = p >>> 24;
        exp_dc = clip14(avgw);
        dc_clip = (avgw != exp_dc);
        exp_ac = clip14(longint'(x) - exp_dc);
        ac_clip = ((longint'(x) - exp_dc) != exp_ac);
    endtask

    // one sample: drive, wait two rising edges, compare
    task automatic send(int x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 14'(x);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        model_take(x);
        chk((mcnt == mwin) ? "R2 first pulse" : "R7 valid", out_valid, exp_v);
        if (exp_v) begin
            chk(dc_clip ? "R6 dc clamp" : "R3 dc", dc_out, exp_dc);
            chk(ac_clip ? "R5 ac clamp" : "R4 ac", ac_out, exp_ac);
        end
    endtask

    // select change in an idle cycle, optionally with a strobed sample that must be dropped
    task automatic change_sel(int sel, bit with_sample, int x);
        @(negedge clk);
        freq_sel = sel[0];
        in_valid = with_sample;
        in_data = 14'(x);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        model_restart(sel);
        chk("R9 no pulse on restart", out_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int x;
        logic signed [13:0] held;
        model_restart(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 ac_out", ac_out, 0);
        chk("R1 dc_out", dc_out, 0);

        // table walk
        for (int s = 0; s < 5; s++) begin
            if (TBL[s][0] != cur_sel) change_sel(TBL[s][0], 1'b0, 0);
            for (int i = 0; i < TBL[s][4]; i++) begin
                case (TBL[s][1])
                    0: x = TBL[s][3];
                    1: x = TBL[s][3] + ((i % 2) ? -TBL[s][2] : TBL[s][2]);
                    default: x = ((i * 37) % 16384) - 8192;
                endcase
                send(x);
            end
        end

        // R10 and R8: idle cycles after a result
        held = ac_out;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R10 idle no pulse", out_valid, 0);
            chk("R8 ac hold", ac_out, held);
        end
        // R10: idle cycles did not advance the window (model unchanged)
        send(1234);

        // R9: sample strobed with a select change is discarded
        change_sel(1, 1'b1, 8191);
        for (int i = 0; i < 833; i++) send(100);
        chk("R9 dc after restart", dc_out, 100);
        chk("R9 ac after restart", ac_out, 0);

        // R5 upper-to-lower clamp
        change_sel(0, 1'b0, 0);
        for (int i = 0; i < 1000; i++) send(8191);
        send(-8192);
        chk("R5 negative clamp", ac_out, -8192);

        // R5 lower-to-upper clamp
        change_sel(1, 1'b0, 0);
        change_sel(0, 1'b0, 0);
        for (int i = 0; i < 1000; i++) send(-8192);
        send(8191);
        chk("R5 positive clamp", ac_out, 8191);

        // R1: reset in mid-run
        for (int i = 0; i < 10; i++) send(777);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_restart(0);
        @(negedge clk);
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset ac", ac_out, 0);
        chk("R1 reset dc", dc_out, 0);
        for (int i = 0; i < 1000; i++) send(-2500);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule